// File: doc/BRIEF.md
# Video Sync Monitor

This block watches the timing of a received video stream in the pixel clock domain. It measures two things. The first is the length of every active line, counted in pixel clocks while data enable is high. The second is the number of active lines between two rising edges of vertical sync. It keeps the last measurement on each axis as a reference, so that it can tell apart two kinds of fault. In the first, the stream is unstable: a line or frame differs from the one before it. In the second, the stream is stable but does not match the resolution that software expects.

Software programs the expected pixels per line and the expected lines per frame. It reads back the measured values and four sticky fault flags. It clears any flag with a one-cycle write-one-to-clear strobe. A measured value is meaningful only while the out-of-sync flag of its axis is clear. Line boundaries come from data enable alone; no horizontal sync input is needed.

Top module: `vid_sync_monitor`

## Requirements
- R1: A line's length is the number of clocks on which `de` was sampled high, from its rising edge to its falling edge. `meas_h` takes the new value on the second rising clock edge after the first edge that samples `de` low, and it holds its value otherwise.
- R2: After reset, the following set up the reference only and never raise a flag: a line already in progress when reset ends, the first vsync rising edge, the first complete line and the first complete frame.
- R3: `flags[2]` (horizontal out-of-sync) sets when a completed line's length differs from the previous line's length.
- R4: `flags[3]` (vertical out-of-sync) sets when a completed frame's line count differs from the previous frame's line count.
- R5: `flags[0]` (horizontal mismatch) sets when a line equals the previous line's length but differs from `exp_h`. It never sets in the same cycle as `flags[2]`.
- R6: `flags[1]` (vertical mismatch) sets when a frame equals the previous frame's line count but differs from `exp_v`.
- R7: A frame's line count is the number of `de` falling edges between two vsync rising edges. `meas_v` takes it on the second rising clock edge after the edge that samples the vsync rise.
- R8: Each flag stays set until a cycle in which its bit of `clr_flags` is 1. A `clr_flags` bit of 0 has no effect on its flag.
- R9: If a clear strobe and a new set condition for the same flag meet in one cycle, the flag ends up set.
- R10: The pixel and line counters saturate at 2^16-1 = 65535 and do not wrap.
- R11: A measurement that equals both the previous one and the programmed value raises no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync | input | 1 | Vertical sync; its rising edge ends a frame |
| de | input | 1 | Data enable; high on active pixels |
| exp_h | input | 16 | Expected pixels per line |
| exp_v | input | 16 | Expected lines per frame |
| clr_flags | input | 4 | Write-one-to-clear strobe, one bit per flag |
| meas_h | output | 16 | Last measured line length |
| meas_v | output | 16 | Last measured frame line count |
| flags | output | 4 | Sticky flags: [0] h mismatch, [1] v mismatch, [2] h out-of-sync, [3] v out-of-sync |

## Verification
A line result reaches `meas_h` and `flags` two rising edges after the edge that first samples `de` low. A frame result reaches `meas_v` and `flags` two edges after the edge that samples the vsync rise. A clear acts on the single edge that samples the strobe. The bench drives all inputs on falling edges and reads the outputs on falling edges. For R1 it reads one falling edge early to confirm the old value, then one edge later to see the new value. The set-versus-clear collision is aimed at exactly the edge where the flag would set.

// File: rtl/vsm_pkg.sv
package vsm_pkg;

    parameter int VSM_CW = 16;
    localparam int NUM_FLAGS = 4;
    localparam int NUM_AXES = 2;

    typedef logic [VSM_CW-1:0] cnt_t;

    // one completed measurement on an axis
    typedef struct packed {
        logic done;
        cnt_t len;
    } meas_t;

    // per-axis outcome of comparing a measurement
    typedef struct packed {
        logic oos;
        logic mis;
    } verdict_t;

    // flag bit positions visible to software
    typedef enum int unsigned {
        FLG_H_MIS = 0,
        FLG_V_MIS = 1,
        FLG_H_OOS = 2,
        FLG_V_OOS = 3
    } flag_e;

    function automatic cnt_t sat_inc(cnt_t v);
        return (v == '1) ? v : v + cnt_t'(1);
    endfunction

endpackage

// File: rtl/vsm_meter.sv
module vsm_meter
    import vsm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  de,
    input  logic  vsync,
    output meas_t h_evt,
    output meas_t v_evt
);

    logic de_q, vs_q;
    logic h_armed, v_armed;
    cnt_t pix_cnt, line_cnt, line_fin;
    logic de_rise, de_fall, vs_rise, line_end;

    assign de_rise  = de & ~de_q;
    assign de_fall  = ~de & de_q;
    assign vs_rise  = vsync & ~vs_q;
    assign line_end = de_fall & h_armed;
    assign line_fin = line_end ? sat_inc(line_cnt) : line_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            // edge history starts high so a level held through reset is no edge
            de_q     <= 1'b1;
            vs_q     <= 1'b1;
            h_armed  <= 1'b0;
            v_armed  <= 1'b0;
            pix_cnt  <= '0;
            line_cnt <= '0;
            h_evt    <= '0;
            v_evt    <= '0;
        end else begin
            de_q       <= de;
            vs_q       <= vsync;
            h_evt.done <= 1'b0;
            v_evt.done <= 1'b0;

            if (de_rise) begin
                pix_cnt <= cnt_t'(1);
                h_armed <= 1'b1;
            end else if (de) begin
                pix_cnt <= sat_inc(pix_cnt);
            end

            if (line_end) begin
                h_evt.done <= 1'b1;
                h_evt.len  <= pix_cnt;
            end

            if (vs_rise) begin
                if (v_armed) begin
                    v_evt.done <= 1'b1;
                    v_evt.len  <= line_fin;
                end
                v_armed  <= 1'b1;
                line_cnt <= '0;
            end else if (line_end && v_armed) begin
                line_cnt <= sat_inc(line_cnt);
            end
        end
    end

endmodule

// File: rtl/vsm_axis_check.sv
module vsm_axis_check
    import vsm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  meas_t    evt,
    input  cnt_t     expected,
    output cnt_t     meas,
    output verdict_t verdict
);

    logic have_ref;
    logic same;

    assign same        = (evt.len == meas);
    assign verdict.oos = evt.done & have_ref & ~same;
    assign verdict.mis = evt.done & have_ref & same & (evt.len != expected);

    // the last measurement doubles as the reference for the next one
    always_ff @(posedge clk) begin
        if (rst) begin
            have_ref <= 1'b0;
            meas     <= '0;
        end else if (evt.done) begin
            have_ref <= 1'b1;
            meas     <= evt.len;
        end
    end

endmodule

// File: rtl/vsm_sticky.sv
module vsm_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags
);

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr_vec) | set_vec;
    end

endmodule

// File: rtl/vid_sync_monitor.sv
module vid_sync_monitor
    import vsm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vsync,
    input  logic                 de,
    input  logic [VSM_CW-1:0]    exp_h,
    input  logic [VSM_CW-1:0]    exp_v,
    input  logic [NUM_FLAGS-1:0] clr_flags,
    output logic [VSM_CW-1:0]    meas_h,
    output logic [VSM_CW-1:0]    meas_v,
    output logic [NUM_FLAGS-1:0] flags
);

    meas_t    evt  [NUM_AXES];
    cnt_t     expv [NUM_AXES];
    cnt_t     meas [NUM_AXES];
    verdict_t vd   [NUM_AXES];
    logic [NUM_FLAGS-1:0] set_vec;
    logic h_done_w, v_done_w;

    vsm_meter u_meter (
        .clk   (clk),
        .rst   (rst),
        .de    (de),
        .vsync (vsync),
        .h_evt (evt[0]),
        .v_evt (evt[1])
    );

    assign expv[0] = exp_h;
    assign expv[1] = exp_v;

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        vsm_axis_check u_axis (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt[a]),
            .expected (expv[a]),
            .meas     (meas[a]),
            .verdict  (vd[a])
        );
    end

    always_comb begin
        set_vec            = '0;
        set_vec[FLG_H_MIS] = vd[0].mis;
        set_vec[FLG_V_MIS] = vd[1].mis;
        set_vec[FLG_H_OOS] = vd[0].oos;
        set_vec[FLG_V_OOS] = vd[1].oos;
    end

    vsm_sticky #(.N(NUM_FLAGS)) u_sticky (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_flags),
        .flags   (flags)
    );

    assign meas_h   = meas[0];
    assign meas_v   = meas[1];
    assign h_done_w = evt[0].done;
    assign v_done_w = evt[1].done;

endmodule

// File: rtl/vsm_checker.sv
module vsm_checker
    import vsm_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_FLAGS-1:0] flags,
    input logic [NUM_FLAGS-1:0] clr_flags,
    input logic [NUM_FLAGS-1:0] set_vec,
    input logic                 h_done,
    input logic                 v_done,
    input logic [VSM_CW-1:0]    meas_h,
    input logic [VSM_CW-1:0]    meas_v
);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        p_sticky_hold_r8: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !clr_flags[i]) |=> flags[i]);
        p_clear_works_r8: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && clr_flags[i] && !set_vec[i]) |=> !flags[i]);
        p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> flags[i]);
    end

    p_hoos_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FLG_H_OOS]) |-> $past(h_done));
    p_voos_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FLG_V_OOS]) |-> $past(v_done));
    p_vmis_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FLG_V_MIS]) |-> $past(v_done));
    p_h_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(set_vec[FLG_H_MIS] && set_vec[FLG_H_OOS]));
    p_meas_h_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(h_done) |-> $stable(meas_h));
    p_meas_v_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(v_done) |-> $stable(meas_v));

endmodule

bind vid_sync_monitor vsm_checker u_vsm_checker (
    .clk       (clk),
    .rst       (rst),
    .flags     (flags),
    .clr_flags (clr_flags),
    .set_vec   (set_vec),
    .h_done    (h_done_w),
    .v_done    (v_done_w),
    .meas_h    (meas_h),
    .meas_v    (meas_v)
);

// File: tb/vid_sync_monitor_bench.sv
`timescale 1ns/1ps
module vid_sync_monitor_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vsync = 1'b0;
    logic        de = 1'b0;
    logic [15:0] exp_h = 16'd0;
    logic [15:0] exp_v = 16'd0;
    logic [3:0]  clr_flags = 4'd0;
    logic [15:0] meas_h, meas_v;
    logic [3:0]  flags;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vid_sync_monitor u_vid_sync_monitor (
        .clk       (clk),
        .rst       (rst),
        .vsync     (vsync),
        .de        (de),
        .exp_h     (exp_h),
        .exp_v     (exp_v),
        .clr_flags (clr_flags),
        .meas_h    (meas_h),
        .meas_v    (meas_v),
        .flags     (flags)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expd);
        checks++;
        if (act !== expd) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expd);
        end
    endtask

    task automatic gap(input int k);
        repeat (k) @(negedge clk);
    endtask

    // de high for exactly n sampling edges, ends at the negedge that drops it
    task automatic drive_line(input int n);
        @(negedge clk) de = 1'b1;
        repeat (n) @(negedge clk);
        de = 1'b0;
    endtask

    task automatic line(input int n);
        drive_line(n);
        gap(3);
    endtask

    task automatic clear(input logic [3:0] m);
        @(negedge clk) clr_flags = m;
        @(negedge clk) clr_flags = 4'd0;
    endtask

    task automatic vpulse();
        @(negedge clk) vsync = 1'b1;
        @(negedge clk) vsync = 1'b0;
        gap(3);
    endtask

    task automatic frame(input int lines_n);
        for (int i = 0; i < lines_n; i++) line(4);
        vpulse();
    endtask

    task automatic t_reset_state();
        de = 1'b1;              // a line already running through reset
        gap(4);
        chk("R2 reset meas_h", meas_h, 0);
        chk("R2 reset meas_v", meas_v, 0);
        chk("R2 reset flags", flags, 0);
        rst = 1'b0;
    endtask

    task automatic t_partial_line_r2();
        gap(3);
        de = 1'b0;
        gap(3);
        chk("R2 partial line ignored meas_h", meas_h, 0);
        chk("R2 partial line no flag", flags, 0);
    endtask

    task automatic t_first_line_r1();
        exp_h = 16'd10;
        drive_line(8);
        @(negedge clk);
        chk("R1 meas_h not yet updated", meas_h, 0);
        @(negedge clk);
        chk("R1 meas_h updated on second edge", meas_h, 8);
        chk("R2 first line raises no flag", flags, 0);
        gap(2);
    endtask

    task automatic t_h_mismatch_r5();
        line(8);
        chk("R5 stable line differs from exp_h", flags, 4'b0001);
    endtask

    task automatic t_clear_r8();
        clear(4'b0000);
        chk("R8 zero strobe no effect", flags, 4'b0001);
        clear(4'b1110);
        chk("R8 other bits no effect", flags, 4'b0001);
        gap(5);
        chk("R8 flag remains sticky", flags, 4'b0001);
        clear(4'b0001);
        chk("R8 write one clears", flags, 4'b0000);
    endtask

    task automatic t_h_oos_r3();
        line(12);
        chk("R3 line length change sets h oos", flags, 4'b0100);
        chk("R1 meas_h follows new line", meas_h, 12);
        exp_h = 16'd12;
        line(12);
        chk("R8 h oos stays set", flags, 4'b0100);
        clear(4'b0100);
        line(12);
        chk("R11 stable and expected no flag", flags, 4'b0000);
    endtask

    task automatic t_set_wins_r9();
        drive_line(13);
        @(negedge clk) clr_flags = 4'b0100;
        @(negedge clk) clr_flags = 4'b0000;
        chk("R9 set beats clear same cycle", flags, 4'b0100);
        gap(3);
        clear(4'b1111);
        chk("R8 clear all", flags, 4'b0000);
    endtask

    task automatic t_vertical();
        exp_h = 16'd4;
        exp_v = 16'd3;
        line(4);
        clear(4'b1111);
        vpulse();
        chk("R2 first vsync only arms", meas_v, 0);
        chk("R2 arming raises no flag", flags, 0);
        frame(3);
        chk("R7 frame line count", meas_v, 3);
        chk("R2 first frame raises no flag", flags, 0);
        frame(3);
        chk("R11 stable expected frame no flag", flags, 0);
        exp_v = 16'd5;
        frame(3);
        chk("R6 stable frame differs from exp_v", flags, 4'b0010);
        clear(4'b0010);
        frame(4);
        chk("R4 frame count change sets v oos", flags, 4'b1000);
        chk("R7 meas_v follows new frame", meas_v, 4);
    endtask

    task automatic t_vtiming_r7();
        clear(4'b1111);
        exp_v = 16'd2;
        line(4);
        line(4);
        @(negedge clk) vsync = 1'b1;
        @(negedge clk) vsync = 1'b0;
        chk("R7 meas_v not yet updated", meas_v, 4);
        @(negedge clk);
        chk("R7 meas_v updated on second edge", meas_v, 2);
        gap(2);
    endtask

    task automatic t_saturate_r10();
        line(70000);
        chk("R10 pixel count saturates", meas_h, 16'hFFFF);
    endtask

    initial begin
        t_reset_state();
        t_partial_line_r2();
        t_first_line_r1();
        t_h_mismatch_r5();
        t_clear_r8();
        t_h_oos_r3();
        t_set_wins_r9();
        t_vertical();
        t_vtiming_r7();
        t_saturate_r10();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule